// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block turns architected register numbers into physical register numbers for a group of up to two instructions each cycle. A 32-entry map table holds the physical register that currently carries each architected register's value. A circular queue holds the physical registers that are not in use. A group of instructions enters on a valid/ready handshake. Its renamed register tags are shown on the output side in the same cycle, gated by a matching valid/ready pair.

Each destination write takes a fresh physical register from the queue. The mapping it replaces is reported so that the reorder buffer can keep it. When that instruction commits, the reorder buffer hands the replaced register back on the commit pins, and it rejoins the queue at the tail. A group that carries a branch may ask for a checkpoint. The unit then saves the map table and the queue's read pointer as they stand once that group is applied. A mispredict restores both, which discards every allocation made after the branch.

Back-pressure rules: a group is accepted when `rn_valid` and `rn_ready` are both high. `rn_ready` is low while the downstream `out_ready` is low. It is also low when the queue holds fewer registers than the group needs, when a checkpoint is requested but every snapshot is in use, and during a restore cycle. `out_valid` carries the same conditions except `out_ready`. It never depends on `out_ready`.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architected register i maps to physical register i. The queue holds physical registers 32 to N-1 and hands them out in ascending order.
- R2: A source lookup returns the physical register written into the table by the most recent accepted group that wrote that architected register.
- R3: For a slot that writes a destination, `out_pdst_old` is the destination's mapping before this group and `out_pdst_new` is the next register from the queue. Slot 0 allocates before slot 1, and after acceptance the table maps the destination to the new register.
- R4: If the queue holds fewer registers than the group's destination writes, `fl_stall` is high, `rn_ready` and `out_valid` are low, and nothing is allocated.
- R5: Each register presented with `cm_vld` joins the queue tail, slot 0 before slot 1. It is handed out only after all registers that were already free.
- R6: In one group, a slot-1 source naming slot 0's destination gets slot 0's new register. If both slots write the same destination, slot 1's old register is slot 0's new register and the table ends with slot 1's register.
- R7: Architected register 0 is never renamed. Its sources give physical register 0, and a write to it allocates nothing and reports 0 as both new and old register.
- R8: When a group with `rn_ckpt_req` is accepted, the snapshot whose index is shown on `out_ckpt_id` saves the table and queue read pointer as they stand after that group. Indices are handed out in circular order from 0.
- R9: `br_restore` with index k puts back snapshot k's table and read pointer, so registers allocated after it are handed out again. It frees snapshot k and all younger ones, and blocks renaming in that cycle.
- R10: With all NUM_CKPT snapshots in use, a group with `rn_ckpt_req` raises `br_stall` and is not accepted. `br_free` releases the oldest snapshot.
- R11: While `out_ready` is low, `rn_ready` is low and the group causes no allocation. `out_valid` and the output tags still show the result the group would get.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | Rename group presented |
| rn_ready | output | 1 | Rename group accepted this cycle |
| rn_slot_vld | input | 2 | Per-slot instruction present |
| rn_dst_we | input | 2 | Per-slot destination write |
| rn_dst_arch | input | 2x5 | Per-slot destination architected register |
| rn_src_a | input | 2x5 | Per-slot first source architected register |
| rn_src_b | input | 2x5 | Per-slot second source architected register |
| rn_ckpt_req | input | 1 | Group carries a predicted branch; take a snapshot |
| out_valid | output | 1 | Renamed tags valid |
| out_ready | input | 1 | Downstream can take the renamed group |
| out_psrc_a | output | 2x6 | Per-slot first source physical register |
| out_psrc_b | output | 2x6 | Per-slot second source physical register |
| out_pdst_new | output | 2x6 | Per-slot newly allocated physical register |
| out_pdst_old | output | 2x6 | Per-slot replaced physical register |
| out_ckpt_id | output | 2 | Index of the snapshot the group would take |
| fl_stall | output | 1 | Queue short of registers for the presented group |
| br_stall | output | 1 | Snapshot requested but all are in use |
| cm_vld | input | 2 | Per-slot commit returns a register |
| cm_preg | input | 2x6 | Registers returned at commit |
| br_free | input | 1 | Oldest snapshot's branch resolved correctly |
| br_restore | input | 1 | Mispredict: restore a snapshot |
| br_restore_id | input | 2 | Snapshot index to restore |

## Verification
The hardest states to reach are an exhausted queue and a full set of snapshots. The bench drains the queue by renaming 31 distinct destinations one at a time until a single register is left. It then offers a two-write group to force the stall, and returns registers through the commit pins to show they are reused in FIFO order. For recovery, the bench takes a checkpoint on a group that writes a register, allocates more registers after it, and restores. The next allocation must then hand out again the register taken first after the branch.

// File: rtl/rrn_pkg.sv
package rrn_pkg;
  parameter int unsigned ARCH_REGS = 32;
  localparam int unsigned ARCH_W   = $clog2(ARCH_REGS);
  localparam int unsigned SLOTS    = 2;
endpackage

// File: rtl/rrn_free_list.sv
module rrn_free_list #(
  parameter int NP = 64,
  parameter int NA = 32,
  parameter int NS = 4,
  localparam int PW = $clog2(NP),
  localparam int SW = $clog2(NS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          pop_n,
  output logic [PW-1:0]       pk0,
  output logic [PW-1:0]       pk1,
  output logic [PW:0]         avail,
  input  logic [1:0]          push_vld,
  input  logic [1:0][PW-1:0]  push_reg,
  input  logic                ckpt_wr,
  input  logic [SW-1:0]       ckpt_idx,
  input  logic                rest_en,
  input  logic [SW-1:0]       rest_idx
);
  logic [PW-1:0] mem_q [NP];
  logic [PW:0]   head_q, tail_q, head_nx, tail_p1;
  logic [PW:0]   snap_head_q [NS];
  logic [PW-1:0] head_p1;

  assign head_nx = head_q + (PW+1)'(pop_n);
  assign tail_p1 = tail_q + (PW+1)'(push_vld[0]);
  assign head_p1 = head_q[PW-1:0] + PW'(1);
  assign pk0     = mem_q[head_q[PW-1:0]];
  assign pk1     = mem_q[head_p1];
  assign avail   = tail_q - head_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) mem_q[i] <= (i < NP - NA) ? PW'(NA + i) : '0;
      head_q <= '0;
      tail_q <= (PW+1)'(NP - NA);
    end else begin
      head_q <= rest_en ? snap_head_q[rest_idx] : head_nx;
      if (push_vld[0]) mem_q[tail_q[PW-1:0]] <= push_reg[0];
      if (push_vld[1]) mem_q[tail_p1[PW-1:0]] <= push_reg[1];
      tail_q <= tail_p1 + (PW+1)'(push_vld[1]);
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rst_n) snap_head_q[g] <= '0;
      else if (ckpt_wr && ckpt_idx == SW'(g)) snap_head_q[g] <= head_nx;
    end
  end
endmodule

// File: rtl/rrn_map_table.sv
module rrn_map_table #(
  parameter int NA = 32,
  parameter int NP = 64,
  parameter int NS = 4,
  localparam int PW = $clog2(NP),
  localparam int AW = $clog2(NA),
  localparam int SW = $clog2(NS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [NA-1:0][PW-1:0]  map_q,
  input  logic [1:0]             wr_en,
  input  logic [1:0][AW-1:0]     wr_arch,
  input  logic [1:0][PW-1:0]     wr_preg,
  input  logic                   ckpt_wr,
  input  logic [SW-1:0]          ckpt_idx,
  input  logic                   rest_en,
  input  logic [SW-1:0]          rest_idx
);
  logic [NA-1:0][PW-1:0] tbl_q, tbl_nx;
  logic [NA-1:0][PW-1:0] snap_q [NS];

  assign map_q = tbl_q;

  always_comb begin
    tbl_nx = tbl_q;
    for (int s = 0; s < 2; s++)
      if (wr_en[s]) tbl_nx[wr_arch[s]] = wr_preg[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) tbl_q[i] <= PW'(i);
    end else begin
      tbl_q <= rest_en ? snap_q[rest_idx] : tbl_nx;
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < NA; i++) snap_q[g][i] <= PW'(i);
      end else if (ckpt_wr && ckpt_idx == SW'(g)) begin
        snap_q[g] <= tbl_nx;
      end
    end
  end
endmodule

// File: rtl/rrn_ckpt_ctrl.sv
module rrn_ckpt_ctrl #(
  parameter int NS = 4,
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          release_i,
  input  logic          rest_en,
  input  logic [SW-1:0] rest_idx,
  output logic [SW-1:0] new_id,
  output logic          full
);
  logic [SW-1:0] alloc_q, old_q;
  logic [SW:0]   cnt_q;
  logic          rel_ok;

  assign rel_ok = release_i && cnt_q != '0;
  assign new_id = alloc_q;
  assign full   = cnt_q == (SW+1)'(NS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_q <= '0;
      old_q   <= '0;
      cnt_q   <= '0;
    end else if (rest_en) begin
      alloc_q <= rest_idx;
      cnt_q   <= {1'b0, SW'(rest_idx - old_q)};
    end else begin
      alloc_q <= alloc_q + SW'(take);
      old_q   <= old_q + SW'(rel_ok);
      cnt_q   <= cnt_q + (SW+1)'(take) - (SW+1)'(rel_ok);
    end
  end
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit
  import rrn_pkg::*;
#(
  parameter int NUM_PHYS = 64,
  parameter int NUM_CKPT = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  rn_valid,
  output logic                                  rn_ready,
  input  logic [1:0]                            rn_slot_vld,
  input  logic [1:0]                            rn_dst_we,
  input  logic [1:0][4:0]                       rn_dst_arch,
  input  logic [1:0][4:0]                       rn_src_a,
  input  logic [1:0][4:0]                       rn_src_b,
  input  logic                                  rn_ckpt_req,
  output logic                                  out_valid,
  input  logic                                  out_ready,
  output logic [1:0][$clog2(NUM_PHYS)-1:0]      out_psrc_a,
  output logic [1:0][$clog2(NUM_PHYS)-1:0]      out_psrc_b,
  output logic [1:0][$clog2(NUM_PHYS)-1:0]      out_pdst_new,
  output logic [1:0][$clog2(NUM_PHYS)-1:0]      out_pdst_old,
  output logic [$clog2(NUM_CKPT)-1:0]           out_ckpt_id,
  output logic                                  fl_stall,
  output logic                                  br_stall,
  input  logic [1:0]                            cm_vld,
  input  logic [1:0][$clog2(NUM_PHYS)-1:0]      cm_preg,
  input  logic                                  br_free,
  input  logic                                  br_restore,
  input  logic [$clog2(NUM_CKPT)-1:0]           br_restore_id
);
  localparam int PW = $clog2(NUM_PHYS);
  localparam int SW = $clog2(NUM_CKPT);

  logic [ARCH_REGS-1:0][PW-1:0] map_q;
  logic [PW-1:0] pk0, pk1;
  logic [PW:0]   fl_avail;
  logic [1:0]    wr, need, pop_n, map_wr;
  logic          can_alloc, ck_full, ck_block, fire, ck_take;
  logic [SW-1:0] ck_id;

  for (genvar s = 0; s < SLOTS; s++) begin : g_wr
    assign wr[s] = rn_slot_vld[s] & rn_dst_we[s] & (rn_dst_arch[s] != '0);
  end

  assign need      = {1'b0, wr[0]} + {1'b0, wr[1]};
  assign can_alloc = fl_avail >= (PW+1)'(need);
  assign ck_block  = rn_ckpt_req & ck_full;
  assign out_valid = rn_valid & can_alloc & ~ck_block & ~br_restore;
  assign rn_ready  = out_ready & can_alloc & ~ck_block & ~br_restore;
  assign fire      = rn_valid & rn_ready;
  assign fl_stall  = rn_valid & ~can_alloc;
  assign br_stall  = rn_valid & ck_block;
  assign pop_n     = fire ? need : 2'b00;
  assign map_wr    = fire ? wr : 2'b00;
  assign ck_take   = fire & rn_ckpt_req;
  assign out_ckpt_id = ck_id;

  always_comb begin
    out_pdst_new[0] = wr[0] ? pk0 : '0;
    out_pdst_new[1] = wr[1] ? (wr[0] ? pk1 : pk0) : '0;
    out_pdst_old[0] = wr[0] ? map_q[rn_dst_arch[0]] : '0;
    out_pdst_old[1] = '0;
    if (wr[1])
      out_pdst_old[1] = (wr[0] && rn_dst_arch[1] == rn_dst_arch[0]) ?
                        out_pdst_new[0] : map_q[rn_dst_arch[1]];
    out_psrc_a[0] = map_q[rn_src_a[0]];
    out_psrc_b[0] = map_q[rn_src_b[0]];
    out_psrc_a[1] = (wr[0] && rn_src_a[1] == rn_dst_arch[0]) ?
                    out_pdst_new[0] : map_q[rn_src_a[1]];
    out_psrc_b[1] = (wr[0] && rn_src_b[1] == rn_dst_arch[0]) ?
                    out_pdst_new[0] : map_q[rn_src_b[1]];
  end

  rrn_map_table #(.NA(ARCH_REGS), .NP(NUM_PHYS), .NS(NUM_CKPT)) u_map (
    .clk(clk), .rst_n(rst_n), .map_q(map_q),
    .wr_en(map_wr), .wr_arch(rn_dst_arch), .wr_preg(out_pdst_new),
    .ckpt_wr(ck_take), .ckpt_idx(ck_id),
    .rest_en(br_restore), .rest_idx(br_restore_id)
  );

  rrn_free_list #(.NP(NUM_PHYS), .NA(ARCH_REGS), .NS(NUM_CKPT)) u_fl (
    .clk(clk), .rst_n(rst_n), .pop_n(pop_n), .pk0(pk0), .pk1(pk1),
    .avail(fl_avail), .push_vld(cm_vld), .push_reg(cm_preg),
    .ckpt_wr(ck_take), .ckpt_idx(ck_id),
    .rest_en(br_restore), .rest_idx(br_restore_id)
  );

  rrn_ckpt_ctrl #(.NS(NUM_CKPT)) u_ck (
    .clk(clk), .rst_n(rst_n), .take(ck_take), .release_i(br_free),
    .rest_en(br_restore), .rest_idx(br_restore_id),
    .new_id(ck_id), .full(ck_full)
  );
endmodule

// File: rtl/rrn_checker.sv
module rrn_checker
  import rrn_pkg::*;
#(
  parameter int NUM_PHYS = 64
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 rn_valid,
  input logic                                 rn_ready,
  input logic                                 out_valid,
  input logic [1:0]                           rn_slot_vld,
  input logic [1:0]                           rn_dst_we,
  input logic [1:0][4:0]                      rn_dst_arch,
  input logic [1:0][4:0]                      rn_src_a,
  input logic [1:0][$clog2(NUM_PHYS)-1:0]     out_psrc_a,
  input logic [1:0][$clog2(NUM_PHYS)-1:0]     out_pdst_new,
  input logic                                 fl_stall,
  input logic                                 br_stall,
  input logic                                 br_restore,
  input logic [$clog2(NUM_PHYS):0]            fl_avail
);
  logic [1:0] wr_c;
  assign wr_c[0] = rn_slot_vld[0] & rn_dst_we[0] & (rn_dst_arch[0] != '0);
  assign wr_c[1] = rn_slot_vld[1] & rn_dst_we[1] & (rn_dst_arch[1] != '0);

  a_r7_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rn_src_a[0] == '0) |-> out_psrc_a[0] == '0);
  a_r3_fresh_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wr_c == 2'b11) |-> out_pdst_new[0] != out_pdst_new[1]);
  a_r3_new_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wr_c[0]) |-> out_pdst_new[0] != '0);
  a_r4_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fl_stall |-> (!rn_ready && !out_valid));
  a_r10_br_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    br_stall |-> !rn_ready);
  a_r9_restore_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    br_restore |-> !rn_ready);
  a_r5_fl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fl_avail) <= NUM_PHYS - int'(ARCH_REGS));
endmodule

bind reg_rename_unit rrn_checker #(.NUM_PHYS(NUM_PHYS)) u_chk (.*);

// File: tb/tb_reg_rename_unit.sv
module tb_reg_rename_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;
  localparam int NS = 4;
  localparam int NA = 32;

  logic clk = 0;
  logic rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rn_valid, rn_ready, rn_ckpt_req, out_valid, out_ready;
  logic [1:0] rn_slot_vld, rn_dst_we, cm_vld;
  logic [1:0][4:0] rn_dst_arch, rn_src_a, rn_src_b;
  logic [1:0][5:0] out_psrc_a, out_psrc_b, out_pdst_new, out_pdst_old, cm_preg;
  logic [1:0] out_ckpt_id, br_restore_id;
  logic fl_stall, br_stall, br_free, br_restore;

  reg_rename_unit #(.NUM_PHYS(NP), .NUM_CKPT(NS)) dut (.*);

  int checks = 0;
  int errors = 0;
  int m_map [NA];
  int m_fl [NP];
  int m_h, m_t, m_alloc, m_old, m_cnt;
  int s_map [NS][NA];
  int s_h [NS];

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    rn_valid = 0; rn_slot_vld = 0; rn_dst_we = 0; rn_dst_arch = '0;
    rn_src_a = '0; rn_src_b = '0; rn_ckpt_req = 0; out_ready = 1;
    cm_vld = 0; cm_preg = '0; br_free = 0; br_restore = 0; br_restore_id = 0;
  endtask

  task automatic slot(int s, bit we, int d, int a, int b);
    rn_valid = 1;
    rn_slot_vld[s] = 1'b1;
    rn_dst_we[s] = we;
    rn_dst_arch[s] = 5'(d);
    rn_src_a[s] = 5'(a);
    rn_src_b[s] = 5'(b);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    for (int i = 0; i < NA; i++) m_map[i] = i;
    for (int i = 0; i < NP; i++) m_fl[i] = (i < NP - NA) ? NA + i : 0;
    m_h = 0; m_t = NP - NA; m_alloc = 0; m_old = 0; m_cnt = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // One clock with the inputs already set: compare against the model, then advance.
  task automatic cycle(string tag);
    int w0, w1, need, n0, n1, o0, o1;
    bit can, ckfull, exp_rdy, exp_ov, fire;
    #1;
    w0 = (rn_slot_vld[0] && rn_dst_we[0] && rn_dst_arch[0] != 0) ? 1 : 0;
    w1 = (rn_slot_vld[1] && rn_dst_we[1] && rn_dst_arch[1] != 0) ? 1 : 0;
    need = w0 + w1;
    can = (m_t - m_h) >= need;
    ckfull = (m_cnt == NS);
    exp_ov = rn_valid && can && !(rn_ckpt_req && ckfull) && !br_restore;
    exp_rdy = out_ready && can && !(rn_ckpt_req && ckfull) && !br_restore;
    chk({tag, " rn_ready"}, int'(rn_ready), int'(exp_rdy));
    chk({tag, " out_valid"}, int'(out_valid), int'(exp_ov));
    chk({tag, " fl_stall"}, int'(fl_stall), int'(rn_valid && !can));
    chk({tag, " br_stall"}, int'(br_stall), int'(rn_valid && rn_ckpt_req && ckfull));
    n0 = 0; n1 = 0;
    if (exp_ov) begin
      n0 = w0 ? m_fl[m_h % NP] : 0;
      n1 = w1 ? m_fl[(m_h + w0) % NP] : 0;
      o0 = w0 ? m_map[rn_dst_arch[0]] : 0;
      o1 = w1 ? ((w0 && rn_dst_arch[1] == rn_dst_arch[0]) ? n0 : m_map[rn_dst_arch[1]]) : 0;
      chk({tag, " new0"}, int'(out_pdst_new[0]), n0);
      chk({tag, " new1"}, int'(out_pdst_new[1]), n1);
      chk({tag, " old0"}, int'(out_pdst_old[0]), o0);
      chk({tag, " old1"}, int'(out_pdst_old[1]), o1);
      chk({tag, " srcA0"}, int'(out_psrc_a[0]), m_map[rn_src_a[0]]);
      chk({tag, " srcB0"}, int'(out_psrc_b[0]), m_map[rn_src_b[0]]);
      chk({tag, " srcA1"}, int'(out_psrc_a[1]),
          (w0 && rn_src_a[1] == rn_dst_arch[0]) ? n0 : m_map[rn_src_a[1]]);
      chk({tag, " srcB1"}, int'(out_psrc_b[1]),
          (w0 && rn_src_b[1] == rn_dst_arch[0]) ? n0 : m_map[rn_src_b[1]]);
      if (rn_ckpt_req) chk({tag, " ckpt_id"}, int'(out_ckpt_id), m_alloc);
    end
    fire = rn_valid && exp_rdy;
    @(posedge clk);
    if (fire) begin
      if (w0) m_map[rn_dst_arch[0]] = n0;
      if (w1) m_map[rn_dst_arch[1]] = n1;
      m_h += need;
      if (rn_ckpt_req) begin
        s_map[m_alloc] = m_map;
        s_h[m_alloc] = m_h;
        m_alloc = (m_alloc + 1) % NS;
        m_cnt++;
      end
    end
    for (int s = 0; s < 2; s++)
      if (cm_vld[s]) begin
        m_fl[m_t % NP] = cm_preg[s];
        m_t++;
      end
    if (br_restore) begin
      m_map = s_map[br_restore_id];
      m_h = s_h[br_restore_id];
      m_alloc = br_restore_id;
      m_cnt = (int'(br_restore_id) - m_old + NS) % NS;
    end else if (br_free && m_cnt > 0) begin
      m_old = (m_old + 1) % NS;
      m_cnt--;
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset_state();
    do_reset();
    slot(0, 0, 0, 5, 31);
    #1;
    chk("R1 reset ready", int'(rn_ready), 1);
    chk("R1 identity srcA", int'(out_psrc_a[0]), 5);
    chk("R1 identity srcB", int'(out_psrc_b[0]), 31);
    cycle("R1");
  endtask

  task automatic t_single();
    do_reset();
    slot(0, 1, 3, 3, 0);
    #1;
    chk("R3 first alloc", int'(out_pdst_new[0]), 32);
    chk("R3 old mapping", int'(out_pdst_old[0]), 3);
    chk("R2 src before write", int'(out_psrc_a[0]), 3);
    cycle("R3");
    slot(0, 1, 3, 3, 0);
    #1;
    chk("R2 newest mapping", int'(out_psrc_a[0]), 32);
    chk("R3 second alloc", int'(out_pdst_new[0]), 33);
    chk("R3 old is prior new", int'(out_pdst_old[0]), 32);
    cycle("R2");
  endtask

  task automatic t_dual();
    do_reset();
    slot(0, 1, 4, 1, 0);
    slot(1, 1, 4, 4, 5);
    #1;
    chk("R6 slot0 new", int'(out_pdst_new[0]), 32);
    chk("R6 slot1 new", int'(out_pdst_new[1]), 33);
    chk("R6 bypass srcA1", int'(out_psrc_a[1]), 32);
    chk("R6 same dest old1", int'(out_pdst_old[1]), 32);
    cycle("R6");
    slot(0, 0, 0, 4, 0);
    #1;
    chk("R6 table holds slot1", int'(out_psrc_a[0]), 33);
    cycle("R6 after");
  endtask

  task automatic t_zero();
    do_reset();
    slot(0, 1, 0, 0, 0);
    slot(1, 1, 9, 0, 0);
    #1;
    chk("R7 r0 new", int'(out_pdst_new[0]), 0);
    chk("R7 r0 old", int'(out_pdst_old[0]), 0);
    chk("R7 no alloc for r0", int'(out_pdst_new[1]), 32);
    chk("R7 src r0", int'(out_psrc_a[1]), 0);
    cycle("R7");
    slot(0, 0, 0, 0, 9);
    #1;
    chk("R7 r0 still zero", int'(out_psrc_a[0]), 0);
    cycle("R7 after");
  endtask

  task automatic t_freelist();
    do_reset();
    for (int i = 0; i < 31; i++) begin
      slot(0, 1, i + 1, 0, 0);
      cycle("R3 fill");
    end
    slot(0, 1, 1, 0, 0);
    slot(1, 1, 2, 0, 0);
    #1;
    chk("R4 short stall", int'(fl_stall), 1);
    chk("R4 not ready", int'(rn_ready), 0);
    cycle("R4");
    slot(0, 1, 5, 0, 0);
    #1;
    chk("R4 nothing taken", int'(out_pdst_new[0]), 63);
    cycle("R4 last");
    slot(0, 1, 6, 0, 0);
    #1;
    chk("R4 empty stall", int'(fl_stall), 1);
    cycle("R4 empty");
    cm_vld = 2'b11; cm_preg[0] = 6'd5; cm_preg[1] = 6'd1;
    cycle("R5 commit");
    slot(0, 1, 6, 0, 0);
    slot(1, 1, 7, 0, 0);
    #1;
    chk("R5 reuse first", int'(out_pdst_new[0]), 5);
    chk("R5 reuse second", int'(out_pdst_new[1]), 1);
    cycle("R5");
  endtask

  task automatic t_restore();
    do_reset();
    slot(0, 1, 7, 0, 0);
    rn_ckpt_req = 1;
    #1;
    chk("R8 first id", int'(out_ckpt_id), 0);
    cycle("R8");
    slot(0, 1, 7, 0, 0);
    slot(1, 1, 8, 0, 0);
    cycle("R8 after branch");
    br_restore = 1; br_restore_id = 0;
    slot(0, 1, 9, 0, 0);
    #1;
    chk("R9 blocked", int'(rn_ready), 0);
    cycle("R9 restore");
    slot(0, 1, 9, 7, 8);
    rn_ckpt_req = 1;
    #1;
    chk("R9 r7 restored", int'(out_psrc_a[0]), 32);
    chk("R9 r8 restored", int'(out_psrc_b[0]), 8);
    chk("R9 head rolled back", int'(out_pdst_new[0]), 33);
    chk("R9 snapshot freed", int'(out_ckpt_id), 0);
    cycle("R9");
  endtask

  task automatic t_ckpt_full();
    do_reset();
    for (int i = 0; i < NS; i++) begin
      rn_valid = 1; rn_ckpt_req = 1;
      #1;
      chk("R8 circular id", int'(out_ckpt_id), i);
      cycle("R10 take");
    end
    rn_valid = 1; rn_ckpt_req = 1;
    #1;
    chk("R10 full stall", int'(br_stall), 1);
    chk("R10 not ready", int'(rn_ready), 0);
    cycle("R10 full");
    br_free = 1;
    cycle("R10 free");
    rn_valid = 1; rn_ckpt_req = 1;
    #1;
    chk("R10 ready again", int'(rn_ready), 1);
    chk("R10 wrapped id", int'(out_ckpt_id), 0);
    cycle("R10");
  endtask

  task automatic t_backpressure();
    do_reset();
    slot(0, 1, 3, 0, 0);
    out_ready = 0;
    #1;
    chk("R11 not ready", int'(rn_ready), 0);
    chk("R11 still valid", int'(out_valid), 1);
    chk("R11 shown tag", int'(out_pdst_new[0]), 32);
    cycle("R11 held");
    slot(0, 1, 3, 3, 0);
    #1;
    chk("R11 no alloc while held", int'(out_pdst_new[0]), 32);
    chk("R11 table unchanged", int'(out_psrc_a[0]), 3);
    cycle("R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    t_reset_state();
    t_single();
    t_dual();
    t_zero();
    t_freelist();
    t_restore();
    t_ckpt_full();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule